// File: doc/BRIEF.md
# Flash Reset and Block-Protection Controller

This block sits beside the program/erase engine of a byte-wide boot-block flash array of 256K x 8. It splits the 18-bit byte address into seven blocks of unequal size: one 16 KB boot block, two 8 KB parameter blocks, one 32 KB main block and three 64 KB main blocks. It keeps one protection bit per block and tells the engine, for each request, whether the target block may be programmed or erased. A parameter chooses the layout. In top-boot layout the boot block sits at the highest addresses. In bottom-boot layout it sits at the lowest addresses. Block indices always rise with address.

A three-level reset/unlock input arrives as a 2-bit encoded level. If the low level lasts long enough, it takes a hardware reset. A reset during an active engine operation aborts that operation. After release, the ready time depends on whether an operation was running when the reset was taken. The high-voltage level lifts every block's protection for as long as it is applied. All thresholds are given in nanoseconds and turned into clock counts from a clock-period parameter.

Top module: `flash_guard`

## Requirements
- R1: In top-boot layout (`TOP_BOOT=1`), `blockIdx` maps 00000h–0FFFFh→0, 10000h–1FFFFh→1, 20000h–2FFFFh→2, 30000h–37FFFh→3, 38000h–39FFFh→4, 3A000h–3BFFFh→5 and 3C000h–3FFFFh→6 (the boot block).
- R2: In bottom-boot layout (`TOP_BOOT=0`), `blockIdx` maps 00000h–03FFFh→0 (the boot block), 04000h–05FFFh→1, 06000h–07FFFh→2, 08000h–0FFFFh→3, 10000h–1FFFFh→4, 20000h–2FFFFh→5 and 30000h–3FFFFh→6.
- R3: `resetLevel` encodes 00 = low, 01 = normal, 10 = high voltage and 11 = normal. A reset is taken on the clock edge that samples low for the ceil(500 ns / period)-th consecutive time, and `busy` rises after that edge. A shorter low run has no effect. `busy` stays high while the input stays low.
- R4: If `engActive` was 0 when the reset was taken, `busy` falls exactly ceil(50 ns / period) cycles after the first edge that samples a non-low level.
- R5: If `engActive` was 1 when the reset was taken, `busy` falls exactly ceil(10 µs / period) cycles after the first edge that samples a non-low level.
- R6: When a reset is taken while `engActive` is 1, `abortPulse` is high for exactly one cycle, starting together with `busy`. When `engActive` is 0, `abortPulse` stays low.
- R7: A `protWrite` pulse with `busy` low sets the protection bit of the block addressed by `addr` to `protValue`. `writeOk[i]` is the inverse of block i's protection bit. A `reqValid` pulse produces, one cycle later, a one-cycle `reqGrant` if the block is writable, or a one-cycle `reqErr` if it is not.
- R8: While `resetLevel` is 10, every bit of `writeOk` is 1 and requests to protected blocks are granted. When the level returns to normal, the stored protection applies again.
- R9: While `busy` is high, `reqValid` yields neither `reqGrant` nor `reqErr`, and `protWrite` leaves the protection bits unchanged.
- R10: Power-on reset (`rstN` low) leaves `busy`, `abortPulse`, `reqGrant` and `reqErr` at 0. It also loads the protection bits from `PROT_INIT` (default: all unprotected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| resetLevel | input | 2 | Encoded three-level reset/unlock input |
| addr | input | 18 | Byte address of the current request |
| engActive | input | 1 | Engine is programming, erasing or erase-suspended |
| reqValid | input | 1 | Engine asks to program/erase at `addr` |
| protWrite | input | 1 | Write the protection bit of the addressed block |
| protValue | input | 1 | New protection bit value (1 = protected) |
| busy | output | 1 | Reset held or recovery interval running |
| abortPulse | output | 1 | One-cycle abort strobe to the engine |
| blockIdx | output | 3 | Decoded block index of `addr` |
| writeOk | output | 7 | Per-block write-allowed qualifier |
| reqGrant | output | 1 | Request accepted, one cycle |
| reqErr | output | 1 | Request aimed at a protected block, one cycle |

## Verification
On every cycle the assertions check these points:
- The abort strobe is a single cycle and only occurs while busy.
- Busy can only rise after a low sample, and holds while the input stays low.
- Grant and error never coincide, and neither follows a busy cycle.
- The high-voltage level opens every block.

Only the bench's scenarios can show the following:
- The exact length of the low run that triggers a reset.
- The two recovery lengths.
- The address boundaries of both layouts.
- That protection is restored after unlock.
- That protection writes are dropped while busy.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

  localparam int NUM_BLOCKS = 7;
  localparam int ADDR_W     = 18;
  localparam int IDX_W      = $clog2(NUM_BLOCKS);

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_NORM = 2'b01,
    LVL_HV   = 2'b10,
    LVL_ALT  = 2'b11
  } level_e;

  typedef struct packed {
    logic busy;
    logic abortStb;
    logic tempUnlock;
    logic acceptReq;
    logic acceptProt;
  } ctrl_strobe_t;

  // Block index for the layout with the boot block at the top of the map.
  function automatic logic [IDX_W-1:0] decodeTop(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] idx;
    case (a[17:16])
      2'd0: idx = IDX_W'(0);
      2'd1: idx = IDX_W'(1);
      2'd2: idx = IDX_W'(2);
      default: begin
        if (!a[15])     idx = IDX_W'(3);
        else if (a[14]) idx = IDX_W'(6);
        else if (a[13]) idx = IDX_W'(5);
        else            idx = IDX_W'(4);
      end
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/flash_guard_ctrl.sv
`timescale 1ns/1ps
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int LOW_MIN_CYC = 50,
  parameter int FAST_CYC    = 5,
  parameter int SLOW_CYC    = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   resetLevel,
  input  logic         engActive,
  input  logic         reqValid,
  input  logic         protWrite,
  output ctrl_strobe_t strobe
);

  localparam int MAX_REC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int LCNT_W  = $clog2(LOW_MIN_CYC + 1);
  localparam int RCNT_W  = $clog2(MAX_REC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HELD, ST_RECOVER} state_e;

  state_e            state;
  logic [LCNT_W-1:0] lowCnt;
  logic [RCNT_W-1:0] recCnt;
  logic [RCNT_W-1:0] recTarget;
  logic              slowSel;
  logic              abortQ;
  logic              isLow;
  logic              takeReset;

  assign isLow     = (resetLevel == LVL_LOW);
  assign takeReset = (state == ST_IDLE) && isLow &&
                     (lowCnt == LCNT_W'(LOW_MIN_CYC - 1));
  assign recTarget = slowSel ? RCNT_W'(SLOW_CYC) : RCNT_W'(FAST_CYC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lowCnt  <= '0;
      recCnt  <= '0;
      slowSel <= 1'b0;
      abortQ  <= 1'b0;
    end else begin
      abortQ <= takeReset && engActive;

      if (state != ST_IDLE || !isLow)
        lowCnt <= '0;
      else if (lowCnt != LCNT_W'(LOW_MIN_CYC))
        lowCnt <= lowCnt + 1'b1;

      case (state)
        ST_IDLE: begin
          if (takeReset) begin
            state   <= ST_HELD;
            slowSel <= engActive;
          end
        end
        ST_HELD: begin
          if (!isLow) begin
            state  <= ST_RECOVER;
            recCnt <= '0;
          end
        end
        ST_RECOVER: begin
          if (isLow)
            state <= ST_HELD;
          else if (recCnt == recTarget - 1'b1)
            state <= ST_IDLE;
          else
            recCnt <= recCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.busy       = (state != ST_IDLE);
    strobe.abortStb   = abortQ;
    strobe.tempUnlock = (resetLevel == LVL_HV);
    strobe.acceptReq  = reqValid && (state == ST_IDLE);
    strobe.acceptProt = protWrite && (state == ST_IDLE);
  end

endmodule

// File: rtl/flash_guard_dp.sv
`timescale 1ns/1ps
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter bit                  TOP_BOOT  = 1'b1,
  parameter logic [NUM_BLOCKS-1:0] PROT_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  protValue,
  input  ctrl_strobe_t          strobe,
  output logic [IDX_W-1:0]      blockIdx,
  output logic [NUM_BLOCKS-1:0] writeOk,
  output logic                  reqGrant,
  output logic                  reqErr
);

  logic [NUM_BLOCKS-1:0] protBits;

  generate
    if (TOP_BOOT) begin : g_top
      assign blockIdx = decodeTop(addr);
    end else begin : g_bottom
      assign blockIdx = IDX_W'(NUM_BLOCKS - 1) - decodeTop(~addr);
    end
  endgenerate

  generate
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_prot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          protBits[g] <= PROT_INIT[g];
        else if (strobe.acceptProt && blockIdx == IDX_W'(g))
          protBits[g] <= protValue;
      end
    end
  endgenerate

  assign writeOk = ~protBits | {NUM_BLOCKS{strobe.tempUnlock}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqGrant <= 1'b0;
      reqErr   <= 1'b0;
    end else begin
      reqGrant <= strobe.acceptReq &&  writeOk[blockIdx];
      reqErr   <= strobe.acceptReq && !writeOk[blockIdx];
    end
  end

endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int          CLK_NS     = 10,
  parameter int          LOW_MIN_NS = 500,
  parameter int          FAST_NS    = 50,
  parameter int          SLOW_NS    = 10000,
  parameter bit          TOP_BOOT   = 1'b1,
  parameter logic [6:0]  PROT_INIT  = 7'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  resetLevel,
  input  logic [17:0] addr,
  input  logic        engActive,
  input  logic        reqValid,
  input  logic        protWrite,
  input  logic        protValue,
  output logic        busy,
  output logic        abortPulse,
  output logic [2:0]  blockIdx,
  output logic [6:0]  writeOk,
  output logic        reqGrant,
  output logic        reqErr
);

  localparam int LOW_MIN_CYC = ((LOW_MIN_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (LOW_MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int FAST_CYC    = ((FAST_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (FAST_NS + CLK_NS - 1) / CLK_NS;
  localparam int SLOW_CYC    = ((SLOW_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (SLOW_NS + CLK_NS - 1) / CLK_NS;

  ctrl_strobe_t strobe;

  flash_guard_ctrl #(
    .LOW_MIN_CYC(LOW_MIN_CYC),
    .FAST_CYC   (FAST_CYC),
    .SLOW_CYC   (SLOW_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .resetLevel(resetLevel),
    .engActive (engActive),
    .reqValid  (reqValid),
    .protWrite (protWrite),
    .strobe    (strobe)
  );

  flash_guard_dp #(
    .TOP_BOOT (TOP_BOOT),
    .PROT_INIT(PROT_INIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .protValue(protValue),
    .strobe   (strobe),
    .blockIdx (blockIdx),
    .writeOk  (writeOk),
    .reqGrant (reqGrant),
    .reqErr   (reqErr)
  );

  assign busy       = strobe.busy;
  assign abortPulse = strobe.abortStb;

endmodule

// File: rtl/flash_guard_chk.sv
`timescale 1ns/1ps
module flash_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] resetLevel,
  input logic       busy,
  input logic       abortPulse,
  input logic [6:0] writeOk,
  input logic       reqGrant,
  input logic       reqErr
);

  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  a_r6_abort_with_busy: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> busy);

  a_r3_busy_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(resetLevel) == 2'b00));

  a_r3_hold_while_low: assert property (@(posedge clk) disable iff (!rstN)
    (busy && resetLevel == 2'b00) |=> busy);

  a_r7_grant_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(reqGrant && reqErr));

  a_r9_quiet_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !(reqGrant || reqErr));

  a_r8_unlock_all: assert property (@(posedge clk) disable iff (!rstN)
    (resetLevel == 2'b10) |-> (writeOk == 7'h7F));

endmodule

bind flash_guard flash_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .resetLevel(resetLevel),
  .busy      (busy),
  .abortPulse(abortPulse),
  .writeOk   (writeOk),
  .reqGrant  (reqGrant),
  .reqErr    (reqErr)
);

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;

  localparam int LOW_MIN = 50;
  localparam int FAST    = 5;
  localparam int SLOW    = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  resetLevel = 2'b01;
  logic [17:0] addr = '0;
  logic [17:0] addrBot = '0;
  logic        engActive = 1'b0;
  logic        reqValid = 1'b0;
  logic        protWrite = 1'b0;
  logic        protValue = 1'b0;
  logic        busy, abortPulse, reqGrant, reqErr;
  logic [2:0]  blockIdx;
  logic [6:0]  writeOk;
  logic        busyB, abortB, grantB, errB;
  logic [2:0]  idxB;
  logic [6:0]  okB;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  grant;
    logic  err;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_guard u_flash_guard (
    .clk(clk), .rstN(rstN), .resetLevel(resetLevel), .addr(addr),
    .engActive(engActive), .reqValid(reqValid), .protWrite(protWrite),
    .protValue(protValue), .busy(busy), .abortPulse(abortPulse),
    .blockIdx(blockIdx), .writeOk(writeOk), .reqGrant(reqGrant), .reqErr(reqErr)
  );

  flash_guard #(.TOP_BOOT(1'b0)) u_flash_guard_bot (
    .clk(clk), .rstN(rstN), .resetLevel(2'b01), .addr(addrBot),
    .engActive(1'b0), .reqValid(1'b0), .protWrite(1'b0),
    .protValue(1'b0), .busy(busyB), .abortPulse(abortB),
    .blockIdx(idxB), .writeOk(okB), .reqGrant(grantB), .reqErr(errB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares grant/error against queued expectations.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cyc) begin
      exp_t e;
      e = expQ.pop_front();
      check({e.tag, " grant"}, 32'(reqGrant), 32'(e.grant));
      check({e.tag, " err"},   32'(reqErr),   32'(e.err));
    end
  end

  task automatic request(input logic [17:0] a, input logic g, input logic e, input string tag);
    exp_t item;
    @(negedge clk);
    addr = a;
    reqValid = 1'b1;
    item.due = cyc + 1; item.grant = g; item.err = e; item.tag = tag;
    expQ.push_back(item);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setProt(input logic [17:0] a, input logic v);
    @(negedge clk);
    addr = a; protWrite = 1'b1; protValue = v;
    @(negedge clk);
    protWrite = 1'b0;
  endtask

  task automatic holdLow(input int n);
    @(negedge clk);
    resetLevel = 2'b00;
    repeat (n) @(negedge clk);
    resetLevel = 2'b01;
  endtask

  task automatic topIdx(input logic [17:0] a, input int exp);
    addr = a; #1;
    check("R1 top decode", 32'(blockIdx), 32'(exp));
  endtask

  task automatic botIdx(input logic [17:0] a, input int exp);
    addrBot = a; #1;
    check("R2 bottom decode", 32'(idxB), 32'(exp));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", 32'(busy), 0);
    check("R10 abort", 32'(abortPulse), 0);
    check("R10 writeOk", 32'(writeOk), 32'h7F);
    check("R10 grant/err", 32'({reqGrant, reqErr}), 0);

    // R1 / R2 decode boundaries
    topIdx(18'h00000, 0); topIdx(18'h1FFFF, 1); topIdx(18'h2ABCD, 2);
    topIdx(18'h30000, 3); topIdx(18'h37FFF, 3); topIdx(18'h38000, 4);
    topIdx(18'h39FFF, 4); topIdx(18'h3A000, 5); topIdx(18'h3BFFF, 5);
    topIdx(18'h3C000, 6); topIdx(18'h3FFFF, 6);
    botIdx(18'h00000, 0); botIdx(18'h03FFF, 0); botIdx(18'h04000, 1);
    botIdx(18'h06000, 2); botIdx(18'h07FFF, 2); botIdx(18'h08000, 3);
    botIdx(18'h0FFFF, 3); botIdx(18'h10000, 4); botIdx(18'h20000, 5);
    botIdx(18'h3FFFF, 6);

    // R7 protection and request outcomes
    setProt(18'h3C000, 1'b1);
    check("R7 writeOk after protect", 32'(writeOk), 32'h3F);
    request(18'h3D123, 1'b0, 1'b1, "R7 protected block");
    request(18'h00010, 1'b1, 1'b0, "R7 open block");
    setProt(18'h38000, 1'b1);
    check("R7 second protect", 32'(writeOk), 32'h2F);
    setProt(18'h38000, 1'b0);
    check("R7 unprotect", 32'(writeOk), 32'h3F);

    // R8 temporary unlock
    @(negedge clk); resetLevel = 2'b10; #1;
    check("R8 all writable", 32'(writeOk), 32'h7F);
    request(18'h3C000, 1'b1, 1'b0, "R8 unlocked grant");
    @(negedge clk); resetLevel = 2'b01; #1;
    check("R8 protection restored", 32'(writeOk), 32'h3F);
    request(18'h3C000, 1'b0, 1'b1, "R8 relocked err");

    // R3 short low run ignored
    holdLow(LOW_MIN - 1);
    check("R3 short pulse busy", 32'(busy), 0);
    @(negedge clk);
    check("R3 short pulse busy later", 32'(busy), 0);

    // R3/R4/R6 full reset, idle engine
    engActive = 1'b0;
    holdLow(LOW_MIN);
    check("R3 busy after reset", 32'(busy), 1);
    check("R6 no abort when idle", 32'(abortPulse), 0);
    repeat (FAST) @(negedge clk);
    check("R4 busy before fast end", 32'(busy), 1);
    @(negedge clk);
    check("R4 ready after fast", 32'(busy), 0);

    // R5/R6 reset during engine operation
    engActive = 1'b1;
    holdLow(LOW_MIN);
    check("R6 abort pulse", 32'(abortPulse), 1);
    check("R5 busy", 32'(busy), 1);
    @(negedge clk);
    engActive = 1'b0;
    check("R6 abort one cycle", 32'(abortPulse), 0);
    repeat (SLOW - 1) @(negedge clk);
    check("R5 busy before slow end", 32'(busy), 1);
    @(negedge clk);
    check("R5 ready after slow", 32'(busy), 0);

    // R9 requests and protection writes ignored while busy
    @(negedge clk); resetLevel = 2'b00;
    repeat (LOW_MIN + 2) @(negedge clk);
    check("R9 held busy", 32'(busy), 1);
    request(18'h00000, 1'b0, 1'b0, "R9 request while busy");
    setProt(18'h00000, 1'b1);
    @(negedge clk); resetLevel = 2'b01;
    repeat (FAST + 2) @(negedge clk);
    check("R9 ready again", 32'(busy), 0);
    check("R9 protection untouched", 32'(writeOk), 32'h3F);
    request(18'h00000, 1'b1, 1'b0, "R9 block 0 still open");

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 32'(expQ.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule